// File: doc/BRIEF.md
# Inter-Thread FIFO Storage Cell

This block is one storage cell of a memory-mapped inter-thread communication area. It holds a small queue of wide words and serves a load channel and a store channel. Every request names the thread that issued it and one of four access views, and the view decides whether the access pushes or pops, peeks or overwrites in place, waits or gives up, or works on the cell's tag instead of its data.

The cell keeps an Empty and a Full tag bit that track the queue, a read-only type bit that marks it as a queue cell, and a bitmap with one bit per thread that shows which threads are currently waiting on the cell. A waiting access keeps its ready low until its condition clears, so the issuing thread simply stalls. Only one operation is carried out per clock; when both channels could proceed, the load goes first.

Top module: `itc_fifo_cell`

## Requirements
- R1: After a synchronous reset the queue is empty: `tag_empty`=1, `tag_full`=0, `blocked_map`=0 and `ld_rvalid`=0.
- R2: View codes are 2'b00 synchronized, 2'b01 try, 2'b10 bypass, 2'b11 control. A store in the synchronized or try view appends its data; a load in these views removes and returns the oldest entry. Load data appears on `ld_rdata` with `ld_rvalid`=1 in the cycle after the load handshake.
- R3: `tag_empty` and `tag_full` follow the number of held entries after every operation; the count never exceeds DEPTH.
- R4: A synchronized load on an empty cell, or a synchronized store on a full cell, holds its ready low until the cell state allows it to complete.
- R5: While a synchronized access is stalled, the `blocked_map` bit of its thread number is 1 from the cycle after the first stalled cycle; it returns to 0 in the cycle after the access completes.
- R6: A try access never stalls: a try load on an empty cell returns 0 and removes nothing, and a try store on a full cell is dropped and leaves the contents unchanged.
- R7: A bypass access never stalls and leaves both tag bits unchanged: a load returns the oldest entry without removing it (0 when empty), and a store replaces the newest entry (no effect when empty).
- R8: A control load returns the tag word: bit 0 Empty, bit 1 Full, bit 2 a constant 1 marking a queue cell, all other bits 0.
- R9: A control store with bit 0 of its data set discards all entries; with bit 0 clear it has no effect.
- R10: At most one operation completes per cycle. When both channels could complete, the load is accepted and the store waits; a store whose load partner is stalled proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request present |
| ld_ready | output | 1 | Load accepted this cycle |
| ld_view | input | 2 | Load access view |
| ld_tid | input | TID_W | Thread number of the load |
| ld_rvalid | output | 1 | Load data valid |
| ld_rdata | output | DATA_W | Load data |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle |
| st_view | input | 2 | Store access view |
| st_tid | input | TID_W | Thread number of the store |
| st_wdata | input | DATA_W | Store data |
| tag_empty | output | 1 | Empty tag bit |
| tag_full | output | 1 | Full tag bit |
| blocked_map | output | THREADS | One bit per thread waiting on the cell |

## Verification
The bench goes after a waiting load that is released by a store in the same stretch of cycles: a design that let the store lose arbitration to a stalled load would deadlock, and one that cleared the waiting bit late would show a stale thread in the bitmap. It fills the cell to its limit with try stores and then pushes once more, which a design without the drop would let wrap over the oldest word. Bypass peeks and overwrites are followed by ordinary pops, so a peek that popped or an overwrite that hit the wrong slot shows up as a wrong order. Control flushes, tag reads and a long random mix compared against a queue model every clock cover the remaining orderings.

// File: rtl/itc_cell_pkg.sv
package itc_cell_pkg;
  typedef enum logic [1:0] {
    VIEW_SYNC   = 2'b00,
    VIEW_TRY    = 2'b01,
    VIEW_BYPASS = 2'b10,
    VIEW_CTRL   = 2'b11
  } view_e;
endpackage

// File: rtl/itc_cell_store.sv
module itc_cell_store #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_pop,
  input  logic              do_push,
  input  logic              do_over,
  input  logic              do_flush,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head_data,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, newest, wa;
  logic [CNT_W-1:0]  count;
  logic              we;

  assign newest    = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
  assign wa        = do_push ? wr_ptr : newest;
  assign we        = do_push | do_over;
  assign head_data = mem[rd_ptr];
  assign empty     = (count == '0);
  assign full      = (count == CMAX);

  // Single write port so the array maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || do_flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (do_push) begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      count  <= count + 1'b1;
    end else if (do_pop) begin
      rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count  <= count - 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CMAX);
  assert_pop_has_data_R2: assert property (@(posedge clk) disable iff (rst)
    do_pop |-> !empty);
  assert_bypass_keeps_count_R7: assert property (@(posedge clk) disable iff (rst)
    do_over |=> count == $past(count));
endmodule

// File: rtl/itc_cell_ctrl.sv
module itc_cell_ctrl
  import itc_cell_pkg::*;
#(
  parameter int THREADS = 4,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  input  logic [1:0]         ld_view,
  input  logic [TID_W-1:0]   ld_tid,
  input  logic               st_valid,
  input  logic [1:0]         st_view,
  input  logic [TID_W-1:0]   st_tid,
  input  logic               st_flush_bit,
  input  logic               empty,
  input  logic               full,
  output logic               ld_ready,
  output logic               st_ready,
  output logic               do_pop,
  output logic               do_push,
  output logic               do_over,
  output logic               do_flush,
  output logic [THREADS-1:0] blocked
);
  view_e lv, sv;
  logic  ld_stall, st_stall, ld_ok, st_ok;
  logic [THREADS-1:0] blk_nxt;

  assign lv = view_e'(ld_view);
  assign sv = view_e'(st_view);

  assign ld_stall = ld_valid && (lv == VIEW_SYNC) && empty;
  assign st_stall = st_valid && (sv == VIEW_SYNC) && full;
  assign ld_ok    = ld_valid && !ld_stall;
  assign st_ok    = st_valid && !st_stall;

  // Load has priority; a stalled load never holds back the store.
  assign ld_ready = ld_ok;
  assign st_ready = st_ok && !ld_ok;

  assign do_pop   = ld_ok && ((lv == VIEW_SYNC) || (lv == VIEW_TRY)) && !empty;
  assign do_push  = st_ready && ((sv == VIEW_SYNC) || ((sv == VIEW_TRY) && !full));
  assign do_over  = st_ready && (sv == VIEW_BYPASS) && !empty;
  assign do_flush = st_ready && (sv == VIEW_CTRL) && st_flush_bit;

  always_comb begin
    blk_nxt = blocked;
    if (ld_stall) blk_nxt[ld_tid] = 1'b1;
    if (st_stall) blk_nxt[st_tid] = 1'b1;
    if (ld_ready) blk_nxt[ld_tid] = 1'b0;
    if (st_ready) blk_nxt[st_tid] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) blocked <= '0;
    else     blocked <= blk_nxt;
  end

  assert_stall_marks_thread_R5: assert property (@(posedge clk) disable iff (rst)
    ld_stall |=> blocked[$past(ld_tid)]);
  assert_single_op_R10: assert property (@(posedge clk) disable iff (rst)
    !(do_pop && do_push));
endmodule

// File: rtl/itc_fifo_cell.sv
module itc_fifo_cell
  import itc_cell_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int DEPTH   = 4,
  parameter int THREADS = 4,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [1:0]         ld_view,
  input  logic [TID_W-1:0]   ld_tid,
  output logic               ld_rvalid,
  output logic [DATA_W-1:0]  ld_rdata,
  input  logic               st_valid,
  output logic               st_ready,
  input  logic [1:0]         st_view,
  input  logic [TID_W-1:0]   st_tid,
  input  logic [DATA_W-1:0]  st_wdata,
  output logic               tag_empty,
  output logic               tag_full,
  output logic [THREADS-1:0] blocked_map
);
  logic do_pop, do_push, do_over, do_flush;
  logic [DATA_W-1:0] head_data, tag_word;

  itc_cell_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .do_pop(do_pop), .do_push(do_push), .do_over(do_over), .do_flush(do_flush),
    .wdata(st_wdata), .head_data(head_data),
    .empty(tag_empty), .full(tag_full)
  );

  itc_cell_ctrl #(.THREADS(THREADS)) u_ctrl (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_view(ld_view), .ld_tid(ld_tid),
    .st_valid(st_valid), .st_view(st_view), .st_tid(st_tid),
    .st_flush_bit(st_wdata[0]),
    .empty(tag_empty), .full(tag_full),
    .ld_ready(ld_ready), .st_ready(st_ready),
    .do_pop(do_pop), .do_push(do_push), .do_over(do_over), .do_flush(do_flush),
    .blocked(blocked_map)
  );

  always_comb begin
    tag_word      = '0;
    tag_word[2:0] = {1'b1, tag_full, tag_empty};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_rvalid <= 1'b0;
      ld_rdata  <= '0;
    end else begin
      ld_rvalid <= ld_ready;
      if (ld_ready) begin
        if (view_e'(ld_view) == VIEW_CTRL) ld_rdata <= tag_word;
        else if (tag_empty)               ld_rdata <= '0;
        else                               ld_rdata <= head_data;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> tag_empty && !tag_full && (blocked_map == '0) && !ld_rvalid);
  assert_sync_load_waits_R4: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready && view_e'(ld_view) == VIEW_SYNC) |-> !tag_empty);
  assert_sync_store_waits_R4: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_ready && view_e'(st_view) == VIEW_SYNC) |-> !tag_full);
  assert_tags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(tag_empty && tag_full));
  assert_data_follows_load_R2: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready) |=> ld_rvalid);
endmodule

// File: tb/itc_fifo_cell_tb.sv
module itc_fifo_cell_tb;
  localparam int DW = 64;
  localparam int D  = 4;
  localparam int T  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 0, st_valid = 0;
  logic [1:0] ld_view = 0, st_view = 0;
  logic [1:0] ld_tid = 0, st_tid = 0;
  logic [DW-1:0] st_wdata = 0;
  logic ld_ready, st_ready, ld_rvalid, tag_empty, tag_full;
  logic [DW-1:0] ld_rdata;
  logic [T-1:0] blocked_map;

  int checks = 0, fails = 0;
  logic [DW-1:0] mq [$];
  logic [T-1:0]  mblk = '0;
  logic          e_rv = 0;
  logic [DW-1:0] e_rd = 0;
  string         rd_req = "R2";

  always #2.5 clk = ~clk;

  itc_fifo_cell #(.DATA_W(DW), .DEPTH(D), .THREADS(T)) u_dut (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_view(ld_view), .ld_tid(ld_tid),
    .ld_rvalid(ld_rvalid), .ld_rdata(ld_rdata),
    .st_valid(st_valid), .st_ready(st_ready), .st_view(st_view), .st_tid(st_tid),
    .st_wdata(st_wdata), .tag_empty(tag_empty), .tag_full(tag_full),
    .blocked_map(blocked_map)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check readies, advance model, check registered outputs.
  task automatic step(logic lv, logic [1:0] lvw, logic [1:0] lt,
                      logic sv, logic [1:0] svw, logic [1:0] stt, logic [DW-1:0] wd);
    logic eld, est;
    int   n;
    ld_valid = lv; ld_view = lvw; ld_tid = lt;
    st_valid = sv; st_view = svw; st_tid = stt; st_wdata = wd;
    #1;
    n   = mq.size();
    eld = lv && !(lvw == 2'b00 && n == 0);
    est = sv && !(svw == 2'b00 && n == D) && !eld;
    chk("R4 R10 load ready", ld_ready, eld);
    chk("R4 R10 store ready", st_ready, est);
    if (lv && lvw == 2'b00 && n == 0) mblk[lt]  = 1'b1;
    if (sv && svw == 2'b00 && n == D) mblk[stt] = 1'b1;
    if (eld) mblk[lt]  = 1'b0;
    if (est) mblk[stt] = 1'b0;
    e_rv = eld;
    if (eld) begin
      if (lvw == 2'b11) begin
        e_rd = '0; e_rd[2:0] = {1'b1, n == D, n == 0}; rd_req = "R8";
      end else begin
        e_rd = (n > 0) ? mq[0] : '0;
        rd_req = (lvw == 2'b10) ? "R7" : (n == 0 ? "R6" : "R2");
        if (lvw != 2'b10 && n > 0) void'(mq.pop_front());
      end
    end
    if (est) begin
      case (svw)
        2'b00: mq.push_back(wd);
        2'b01: if (n < D) mq.push_back(wd);
        2'b10: if (n > 0) mq[n-1] = wd;
        default: if (wd[0]) mq.delete();
      endcase
    end
    @(negedge clk);
    chk("R2 rvalid", ld_rvalid, e_rv);
    if (e_rv) chk(rd_req, ld_rdata, e_rd);
    chk("R3 empty", tag_empty, mq.size() == 0);
    chk("R3 full", tag_full, mq.size() == D);
    chk("R5 blocked", blocked_map, mblk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic hold_l, hold_s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 empty", tag_empty, 1'b1);
    chk("R1 full", tag_full, 1'b0);
    chk("R1 blocked", blocked_map, '0);
    chk("R1 rvalid", ld_rvalid, 1'b0);

    // R4 R5: sync load waits on empty, then a store releases it (R10).
    step(1, 2'b00, 2, 0, 0, 0, '0);
    step(1, 2'b00, 2, 0, 0, 0, '0);
    chk("R5 thread 2 waiting", blocked_map, 4'b0100);
    step(1, 2'b00, 2, 1, 2'b00, 1, 64'hA1);
    step(1, 2'b00, 2, 0, 0, 0, '0);
    chk("R2 released load data", ld_rdata, 64'hA1);
    chk("R5 bit cleared", blocked_map, 4'b0000);

    // R6: fill with try stores, the extra one is dropped.
    for (int i = 0; i < D + 1; i++) step(0, 0, 0, 1, 2'b01, 0, 64'h100 + i);
    chk("R6 full after fill", tag_full, 1'b1);
    // R4: sync store on full waits; then load and store together (R10).
    step(0, 0, 0, 1, 2'b00, 3, 64'hBEEF);
    step(0, 0, 0, 1, 2'b00, 3, 64'hBEEF);
    chk("R5 thread 3 waiting", blocked_map, 4'b1000);
    step(1, 2'b00, 0, 1, 2'b00, 3, 64'hBEEF);
    chk("R10 load first", ld_rdata, 64'h100);
    step(0, 0, 0, 1, 2'b00, 3, 64'hBEEF);
    // R7: bypass peek and overwrite newest.
    step(1, 2'b10, 1, 0, 0, 0, '0);
    chk("R7 peek oldest", ld_rdata, 64'h101);
    step(0, 0, 0, 1, 2'b10, 1, 64'hC0DE);
    chk("R7 tags unchanged", tag_full, 1'b1);
    // R8: tag word read while full.
    step(1, 2'b11, 0, 0, 0, 0, '0);
    chk("R8 tag word", ld_rdata, 64'h6);
    for (int i = 0; i < D; i++) step(1, 2'b01, 0, 0, 0, 0, '0);
    chk("R7 overwritten newest", ld_rdata, 64'hC0DE);
    step(1, 2'b01, 0, 0, 0, 0, '0);
    chk("R6 try on empty", ld_rdata, '0);
    step(1, 2'b10, 0, 0, 0, 0, '0);
    chk("R7 peek on empty", ld_rdata, '0);

    // R9: control store without bit 0, then with it.
    step(0, 0, 0, 1, 2'b01, 0, 64'h55);
    step(0, 0, 0, 1, 2'b11, 0, 64'hFE);
    chk("R9 no flush", tag_empty, 1'b0);
    step(0, 0, 0, 1, 2'b11, 0, 64'h1);
    chk("R9 flushed", tag_empty, 1'b1);
    step(1, 2'b11, 0, 0, 0, 0, '0);
    chk("R9 R8 tag after flush", ld_rdata, 64'h5);
    idle();

    // Random mix; stalled requests are held as the protocol requires.
    hold_l = 0; hold_s = 0;
    for (int c = 0; c < 3000; c++) begin
      logic lv, sv;
      logic [1:0] lvw, svw, lt, stt;
      logic [DW-1:0] wd;
      if (hold_l) begin lv = 1; lvw = ld_view; lt = ld_tid; end
      else begin
        lv = ($urandom_range(0, 99) < 45); lvw = 2'($urandom_range(0, 3));
        if (lvw != 2'b00 && $urandom_range(0, 1) == 1) lvw = 2'b00;
        lt = 2'($urandom_range(0, 1));
      end
      if (hold_s) begin sv = 1; svw = st_view; stt = st_tid; wd = st_wdata; end
      else begin
        sv = ($urandom_range(0, 99) < 55); svw = 2'($urandom_range(0, 3));
        if (svw == 2'b11 && $urandom_range(0, 3) != 0) svw = 2'b00;
        stt = 2'($urandom_range(2, 3)); wd = {32'($urandom), 32'($urandom)};
      end
      step(lv, lvw, lt, sv, svw, stt, wd);
      hold_l = lv && (lvw == 2'b00) && !e_rv;
      hold_s = sv && (svw == 2'b00) && (mblk[stt] == 1'b1);
    end
    for (int k = 0; k < 8; k++) step(1, 2'b01, 0, 0, 0, 0, '0);
    idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule